// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits at the transmit side of a serial link. It decides when the transaction at the head of one traffic class may go onto the wire. The block keeps one credit pool for that class. The pool has a header field and a data field. Each field holds a cumulative limit, which the link partner advertises, and a cumulative count of credits already spent.

During link training the partner sends its first advertisement, and the block loads it as the starting limit. After that, update messages from the partner replace the stored limits. The requester presents one transaction at a time, with its length in bytes, and holds it until the block raises `grant`. A grant spends the credits the transaction needs. A transaction that does not fit stays at the head and blocks everything behind it. Data is counted in 16-byte units.

Top module: `tx_credit_gate`

## Requirements
- R1: After reset, no limit is loaded and `grant` stays low, even with `link_up` high and a request pending.
- R2: A request of L bytes needs one header credit and ceil(L/16) data credits. A zero-length request needs no data credit.
- R3: `grant` is high only while a request is pending and both fields can cover its need. Header availability must be at least 1, and data availability must be at least the data need. Otherwise the request waits, and `grant` stays low until the credits are there.
- R4: A grant adds 1 to the header consumed count and adds the data need to the data consumed count, at the same clock edge. Without a grant, both counts keep their values.
- R5: An update received in one cycle replaces the stored limits at that clock edge. A request that was waiting can be granted in the very next cycle.
- R6: The header counts are 8 bits wide and the data counts are 12 bits wide, and both wrap. Availability is the limit minus the consumed count, taken modulo 2^8 or 2^12.
- R7: If the initial advertisement gives 0 for a field, that field has infinite credit: it never blocks, and later updates leave it infinite.
- R8: No grant is given while `link_up` is low, or before the initial advertisement has been loaded.
- R9: Only the first initial advertisement after reset is taken. Later ones are ignored, and so is any update that arrives before the first advertisement.
- R10: `grant` is never high without `req_valid`. Requests are served strictly one at a time, head first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link training complete |
| init_valid | input | 1 | Initial advertisement strobe |
| init_hdr | input | 8 | Advertised header limit |
| init_dat | input | 12 | Advertised data limit |
| upd_valid | input | 1 | Credit update strobe |
| upd_hdr | input | 8 | Updated header limit |
| upd_dat | input | 12 | Updated data limit |
| req_valid | input | 1 | Head transaction pending |
| req_len | input | 12 | Head transaction length in bytes |
| grant | output | 1 | Head transaction may be sent this cycle |

## Verification
Several properties are checked on every cycle:
- a grant only ever appears with a pending request, after the first advertisement has been loaded and with the link up;
- the consumed counts advance by exactly the need on a grant and hold otherwise;
- updates land in the limit at the next edge;
- late advertisements leave the limits alone.

Other behaviour only the bench's scenarios can show:
- that the rounding of byte lengths is right;
- the exact boundary where availability matches the need;
- the wrap of the modular counts;
- the infinite-credit meaning of a zero advertisement;
- the one-cycle reaction to an update.

// File: rtl/tx_credit_gate.sv
module tx_credit_gate #(
  parameter int HDR_W    = 8,
  parameter int DAT_W    = 12,
  parameter int LEN_W    = 12,
  parameter int UNIT_LG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             init_valid,
  input  logic [HDR_W-1:0] init_hdr,
  input  logic [DAT_W-1:0] init_dat,
  input  logic             upd_valid,
  input  logic [HDR_W-1:0] upd_hdr,
  input  logic [DAT_W-1:0] upd_dat,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  output logic             grant
);
  localparam int UNIT_B = 1 << UNIT_LG2;

  logic             loaded, hdr_inf, dat_inf;
  logic [HDR_W-1:0] hdr_lim, hdr_cons, hdr_av;
  logic [DAT_W-1:0] dat_lim, dat_cons, dat_av, need_d;
  logic [LEN_W:0]   len_up;

  assign len_up = {1'b0, req_len} + (LEN_W+1)'(UNIT_B - 1);
  assign need_d = DAT_W'(len_up >> UNIT_LG2);
  assign hdr_av = hdr_lim - hdr_cons;
  assign dat_av = dat_lim - dat_cons;

  assign grant = req_valid && link_up && loaded &&
                 (hdr_inf || hdr_av != '0) &&
                 (dat_inf || dat_av >= need_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      hdr_inf  <= 1'b0;
      dat_inf  <= 1'b0;
      hdr_lim  <= '0;
      dat_lim  <= '0;
      hdr_cons <= '0;
      dat_cons <= '0;
    end else begin
      if (!loaded && init_valid) begin
        loaded  <= 1'b1;
        hdr_lim <= init_hdr;
        dat_lim <= init_dat;
        hdr_inf <= (init_hdr == '0);
        dat_inf <= (init_dat == '0);
      end else if (loaded && upd_valid) begin
        if (!hdr_inf) hdr_lim <= upd_hdr;
        if (!dat_inf) dat_lim <= upd_dat;
      end
      if (grant) begin
        hdr_cons <= hdr_cons + 1'b1;
        dat_cons <= dat_cons + need_d;
      end
    end
  end
endmodule

module tx_credit_gate_chk #(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             link_up,
  input logic             init_valid,
  input logic             upd_valid,
  input logic [DAT_W-1:0] upd_dat,
  input logic             req_valid,
  input logic             grant,
  input logic             loaded,
  input logic             dat_inf,
  input logic [HDR_W-1:0] hdr_lim,
  input logic [HDR_W-1:0] hdr_cons,
  input logic [DAT_W-1:0] dat_lim,
  input logic [DAT_W-1:0] dat_cons,
  input logic [DAT_W-1:0] need_d
);
  a_r8_grant_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (loaded && link_up));

  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);

  a_r4_consume_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (dat_cons == DAT_W'($past(dat_cons) + $past(need_d))) &&
              (hdr_cons == HDR_W'($past(hdr_cons) + 1'b1)));

  a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> $stable(dat_cons) && $stable(hdr_cons));

  a_r5_update_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && upd_valid && !dat_inf) |=> dat_lim == $past(upd_dat));

  a_r9_late_init_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && init_valid && !upd_valid) |=> $stable(hdr_lim) && $stable(dat_lim));
endmodule

bind tx_credit_gate tx_credit_gate_chk #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .init_valid(init_valid),
  .upd_valid(upd_valid), .upd_dat(upd_dat), .req_valid(req_valid),
  .grant(grant), .loaded(loaded), .dat_inf(dat_inf), .hdr_lim(hdr_lim),
  .hdr_cons(hdr_cons), .dat_lim(dat_lim), .dat_cons(dat_cons), .need_d(need_d)
);

// File: tb/tx_credit_gate_tb.sv
module tx_credit_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n, link_up, init_valid, upd_valid, req_valid;
  logic [7:0]  init_hdr, upd_hdr;
  logic [11:0] init_dat, upd_dat, req_len;
  logic        grant;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  tx_credit_gate u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .init_valid(init_valid),
    .init_hdr(init_hdr), .init_dat(init_dat), .upd_valid(upd_valid),
    .upd_hdr(upd_hdr), .upd_dat(upd_dat), .req_valid(req_valid),
    .req_len(req_len), .grant(grant)
  );

  always #10 clk = ~clk;

  task automatic check(input logic exp, input string tag);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected %b", tag, grant, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; link_up = 1'b0; init_valid = 1'b0; upd_valid = 1'b0;
    req_valid = 1'b0; init_hdr = '0; init_dat = '0; upd_hdr = '0;
    upd_dat = '0; req_len = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [7:0] h, input logic [11:0] d);
    init_valid = 1'b1; init_hdr = h; init_dat = d;
    @(negedge clk);
    init_valid = 1'b0;
    link_up = 1'b1;
  endtask

  task automatic try_send(input logic [11:0] len, input logic exp, input string tag);
    req_valid = 1'b1; req_len = len;
    #1 check(exp, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_startup();
    do_reset();
    link_up = 1'b1; req_valid = 1'b1; req_len = 12'd16;
    #1 check(1'b0, "R1 no grant after reset");
    upd_valid = 1'b1; upd_hdr = 8'd5; upd_dat = 12'd5;
    @(negedge clk);
    upd_valid = 1'b0;
    #1 check(1'b0, "R9 early update ignored");
    link_up = 1'b0;
    init_valid = 1'b1; init_hdr = 8'd2; init_dat = 12'd2;
    @(negedge clk);
    init_valid = 1'b0;
    #1 check(1'b0, "R8 no grant with link down");
    link_up = 1'b1;
    #1 check(1'b1, "R8 grant once link up and loaded");
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_basic();
    do_reset();
    load(8'd8, 12'd5);
    try_send(12'd64, 1'b1, "R2 64 bytes needs 4 of 5");
    req_valid = 1'b1; req_len = 12'd17;
    for (int i = 0; i < 3; i++) begin
      #1 check(1'b0, "R3 17 bytes needs 2, only 1 left");
      @(negedge clk);
    end
    upd_valid = 1'b1; upd_hdr = 8'd8; upd_dat = 12'd6;
    #1 check(1'b0, "R5 no grant in update cycle");
    @(negedge clk);
    upd_valid = 1'b0;
    #1 check(1'b1, "R5 grant the cycle after update");
    @(negedge clk);
    req_valid = 1'b0;
    try_send(12'd1, 1'b0, "R4 data exhausted after grant");
    try_send(12'd0, 1'b1, "R2 zero length needs no data");
  endtask

  task automatic t_header_infinite_data();
    do_reset();
    load(8'd3, 12'd0);
    for (int i = 0; i < 3; i++) try_send(12'd4000, 1'b1, "R7 infinite data");
    try_send(12'd0, 1'b0, "R3 header exhausted");
    upd_valid = 1'b1; upd_hdr = 8'd4; upd_dat = 12'd1;
    @(negedge clk);
    upd_valid = 1'b0;
    try_send(12'd4095, 1'b1, "R7 update keeps data infinite");
  endtask

  task automatic t_wrap();
    do_reset();
    load(8'd250, 12'd4090);
    for (int i = 0; i < 16; i++) try_send(12'd4080, 1'b1, "R6 fill data pool");
    try_send(12'd161, 1'b0, "R3 need 11 with 10 left");
    upd_valid = 1'b1; upd_hdr = 8'd250; upd_dat = 12'd294;
    @(negedge clk);
    upd_valid = 1'b0;
    try_send(12'd4080, 1'b1, "R6 wrapped limit gives 310");
    try_send(12'd881, 1'b0, "R6 need 56 with 55 left");
    try_send(12'd880, 1'b1, "R6 need 55 with 55 left");
  endtask

  task automatic t_late_init();
    do_reset();
    load(8'd1, 12'd1);
    try_send(12'd16, 1'b1, "R9 first advertisement used");
    init_valid = 1'b1; init_hdr = 8'd100; init_dat = 12'd100;
    @(negedge clk);
    init_valid = 1'b0;
    try_send(12'd16, 1'b0, "R9 late advertisement ignored");
    req_valid = 1'b0;
    #1 check(1'b0, "R10 no grant without request");
  endtask

  initial begin
    fork
      begin
        t_startup();
        t_basic();
        t_header_infinite_data();
        t_wrap();
        t_late_init();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: run did not complete, expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule